// File: doc/BRIEF.md
# Fixed-Point Hex Display Formatter

This block turns a 16-bit signed word in Q5.11 format into the drive signals of a four-digit, time-multiplexed, common-anode seven-segment display. The four integer bits appear on the leftmost digit. That digit's decimal point is lit to mark the radix point.

The eleven fraction bits get one zero added below them. The resulting twelve bits appear as three hex digits on the remaining positions. The sign bit is shown on the decimal point of the rightmost digit. The bit pattern is shown exactly as stored, so a negative value appears in its two's-complement form.

A free-running refresh counter moves the scan from the leftmost digit to the rightmost. The input word is captured once per full scan, so digits taken from two different samples never appear together. All outputs are active low and come straight from flops.

Top module: `fxd_seg_display`

## Requirements
- R1: While reset is held, and on the first clock after it, every segment line, the decimal-point line and every digit enable are high (dark).
- R2: The leftmost digit (enable bit 3) shows input bits [14:11] as one hex glyph.
- R3: The second digit (enable bit 2) shows bits [10:7], and the third digit (enable bit 1) shows bits [6:3].
- R4: The rightmost digit (enable bit 0) shows the nibble {bits[2:0], 0}.
- R5: Glyphs use seg_n = {g,f,e,d,c,b,a}, active low. Values 0 to F map to 40,79,24,30,19,12,02,78,00,10,08,03,46,21,06,0E (hex), which includes lowercase b and d.
- R6: The decimal point is lit (dp_n = 0) whenever the leftmost digit is enabled.
- R7: While the rightmost digit is enabled, dp_n is the inverse of the captured bit 15.
- R8: While either middle digit is enabled, dp_n is 1.
- R9: Exactly one digit enable is low at a time. Starting from the leftmost digit after reset, the scan moves one position to the right every 2^REFRESH_BITS clocks and wraps after the rightmost digit.
- R10: The input word is captured on the first clock of each scan. Changes made later in that scan do not appear until the next scan.
- R11: All outputs are registered. The output after a clock edge reflects the counter state and the input word that were present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value | input | 16 | Q5.11 word to display |
| seg_n | output | 7 | Segment lines {g,f,e,d,c,b,a}, active low |
| dp_n | output | 1 | Decimal-point line, active low |
| dig_en_n | output | 4 | Digit enables, bit 3 leftmost, active low |

## Verification
Every result is due one clock after the edge at which its cause is sampled. The new digit enable appears one edge after the refresh counter reaches a boundary, and a new input word becomes visible one edge after the first cycle of a scan. The bench keeps a cycle count since reset and a captured copy of the word. At each rising edge it works out what the flops must hold after that edge, and it compares the ports at the following falling edge. Input changes are placed at falling edges in the middle of a scan, so that the hold behaviour across a scan is exercised.

// File: rtl/fxd_pkg.sv
package fxd_pkg;
  localparam int WORD_W  = 16;
  localparam int FRAC_W  = 11;
  localparam int NDIG    = 4;
  localparam int DIG_W   = $clog2(NDIG);
  localparam int SEG_W   = 7;

  // active-high glyph, bit order {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [3:0] nib);
    case (nib)
      4'h0: hex_glyph = 7'h3F;
      4'h1: hex_glyph = 7'h06;
      4'h2: hex_glyph = 7'h5B;
      4'h3: hex_glyph = 7'h4F;
      4'h4: hex_glyph = 7'h66;
      4'h5: hex_glyph = 7'h6D;
      4'h6: hex_glyph = 7'h7D;
      4'h7: hex_glyph = 7'h07;
      4'h8: hex_glyph = 7'h7F;
      4'h9: hex_glyph = 7'h6F;
      4'hA: hex_glyph = 7'h77;
      4'hB: hex_glyph = 7'h7C;
      4'hC: hex_glyph = 7'h39;
      4'hD: hex_glyph = 7'h5E;
      4'hE: hex_glyph = 7'h79;
      default: hex_glyph = 7'h71;
    endcase
  endfunction

  // one-hot digit select, leftmost digit (index 0) at the MSB
  function automatic logic [NDIG-1:0] digit_mask(input logic [DIG_W-1:0] idx);
    digit_mask = NDIG'(1) << (NDIG - 1 - int'(idx));
  endfunction
endpackage

// File: rtl/fxd_scan_timer.sv
module fxd_scan_timer #(
  parameter int REFRESH_BITS = 16,
  parameter int DIG_W        = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DIG_W-1:0] digit_idx,
  output logic             scan_start,
  output logic             digit_step
);
  logic [REFRESH_BITS-1:0] tick;

  assign digit_step = &tick;
  assign scan_start = (tick == '0) && (digit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick      <= '0;
      digit_idx <= '0;
    end else begin
      tick <= tick + REFRESH_BITS'(1);
      if (digit_step) digit_idx <= digit_idx + DIG_W'(1);
    end
  end

  // R9: digit index only moves at the end of a refresh period
  a_r9_step_only: assert property (@(posedge clk) disable iff (rst)
    !digit_step |=> $stable(digit_idx));
endmodule

// File: rtl/fxd_digit_pick.sv
module fxd_digit_pick
  import fxd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [DIG_W-1:0]  idx,
  output logic [3:0]        nibble,
  output logic              dp_on
);
  localparam int PAD_W = FRAC_W + 1;   // fraction plus one zero bit

  logic [PAD_W-1:0] frac_pad;
  logic [3:0]       digs [NDIG];

  assign frac_pad = {word[FRAC_W-1:0], 1'b0};
  assign digs[0]  = word[WORD_W-2 -: 4];

  for (genvar gi = 1; gi < NDIG; gi++) begin : g_frac
    assign digs[gi] = frac_pad[(NDIG-1-gi)*4 +: 4];
  end

  always_comb begin
    nibble = digs[idx];
    if (idx == '0)                    dp_on = 1'b1;             // radix point
    else if (idx == DIG_W'(NDIG - 1)) dp_on = word[WORD_W-1];   // sign
    else                              dp_on = 1'b0;
  end
endmodule

// File: rtl/fxd_seg_display.sv
module fxd_seg_display
  import fxd_pkg::*;
#(
  parameter int REFRESH_BITS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] value,
  output logic [SEG_W-1:0]  seg_n,
  output logic              dp_n,
  output logic [NDIG-1:0]   dig_en_n
);
  logic [DIG_W-1:0]  digit_idx;
  logic              scan_start;
  logic              digit_step;
  logic [WORD_W-1:0] sample;
  logic [WORD_W-1:0] live_word;
  logic [3:0]        nibble;
  logic              dp_on;

  fxd_scan_timer #(.REFRESH_BITS(REFRESH_BITS), .DIG_W(DIG_W)) i_timer (
    .clk(clk), .rst(rst), .digit_idx(digit_idx),
    .scan_start(scan_start), .digit_step(digit_step)
  );

  // the word seen on the first scan cycle is the one held for the scan
  assign live_word = scan_start ? value : sample;

  always_ff @(posedge clk) begin
    if (rst)             sample <= '0;
    else if (scan_start) sample <= value;
  end

  fxd_digit_pick i_pick (
    .word(live_word), .idx(digit_idx), .nibble(nibble), .dp_on(dp_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n    <= '1;
      dp_n     <= 1'b1;
      dig_en_n <= '1;
    end else begin
      seg_n    <= ~hex_glyph(nibble);
      dp_n     <= ~dp_on;
      dig_en_n <= ~digit_mask(digit_idx);
    end
  end

  // R9: exactly one digit driven once out of reset
  a_r9_one_enable: assert property (@(posedge clk) disable iff (rst)
    !digit_step |=> $countones(~dig_en_n) == 1 || $past(rst));
  // R6: radix point lit with the leftmost digit
  a_r6_left_dp: assert property (@(posedge clk) disable iff (rst)
    !dig_en_n[NDIG-1] |-> !dp_n);
  // R8: middle decimal points dark
  a_r8_mid_dp_dark: assert property (@(posedge clk) disable iff (rst)
    (!dig_en_n[1] || !dig_en_n[2]) |-> dp_n);
  // R10: held word changes only at a scan start
  a_r10_hold_sample: assert property (@(posedge clk) disable iff (rst)
    !scan_start |=> $stable(sample));
endmodule

// File: tb/test_fxd_seg_display.sv
module test_fxd_seg_display;
  localparam int RB   = 2;
  localparam int PER  = 1 << RB;
  localparam int SCAN = 4 * PER;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] value = 16'h0000;
  logic [6:0]  seg_n;
  logic        dp_n;
  logic [3:0]  dig_en_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  fxd_seg_display #(.REFRESH_BITS(RB)) i_fxd_seg_display (
    .clk(clk), .rst(rst), .value(value),
    .seg_n(seg_n), .dp_n(dp_n), .dig_en_n(dig_en_n)
  );

  always #2ns clk = ~clk;   // 250 MHz

  // reference model state
  int          since_rst = 0;
  logic [15:0] held = 16'h0;
  logic [6:0]  exp_seg = 7'h7F;
  logic        exp_dp = 1'b1;
  logic [3:0]  exp_en = 4'hF;
  int          exp_pos = -1;   // -1: reset state

  // R5 table, active low
  function automatic logic [6:0] low_glyph(input int n);
    logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                           7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return t[n];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      since_rst = 0;
      exp_seg = 7'h7F; exp_dp = 1'b1; exp_en = 4'hF; exp_pos = -1;
    end else begin
      int pos, phase, shown, nib;
      phase = since_rst % SCAN;
      if (phase == 0) held = value;
      pos = phase / PER;
      shown = held;
      case (pos)
        0: nib = (shown >> 11) & 15;
        1: nib = (shown >> 7) & 15;
        2: nib = (shown >> 3) & 15;
        default: nib = (shown << 1) & 15;
      endcase
      exp_seg = low_glyph(nib);
      exp_dp  = (pos == 0) ? 1'b0 : (pos == 3) ? ~held[15] : 1'b1;
      exp_en  = 4'hF & ~(4'b1000 >> pos);
      exp_pos = pos;
      since_rst++;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      string rs, rd;
      if (exp_pos < 0) begin rs = "R1"; rd = "R1"; end
      else begin
        case (exp_pos)
          0: rs = "R2 R5 R10 R11";
          1, 2: rs = "R3 R5 R10 R11";
          default: rs = "R4 R5 R10 R11";
        endcase
        rd = (exp_pos == 0) ? "R6" : (exp_pos == 3) ? "R7 R10" : "R8";
      end
      checks += 3;
      if (seg_n !== exp_seg) begin
        errors++;
        $display("FAIL %s seg_n: got %h expected %h at %0t", rs, seg_n, exp_seg, $time);
      end
      if (dp_n !== exp_dp) begin
        errors++;
        $display("FAIL %s dp_n: got %b expected %b at %0t", rd, dp_n, exp_dp, $time);
      end
      if (dig_en_n !== exp_en) begin
        errors++;
        $display("FAIL %s dig_en_n: got %b expected %b at %0t",
                 (exp_pos < 0) ? "R1" : "R9", dig_en_n, exp_en, $time);
      end
    end
  end

  task automatic hold_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    hold_cycles(3);
    rst = 1'b0;
    // R2 R3 R4 R5: every glyph in every position
    for (int n = 0; n < 16; n++) begin
      logic [3:0] d;
      d = 4'(n);
      value = {d[0], d, d, d, d[3:1]};
      hold_cycles(SCAN + 5);
    end
    // R7 R10: sign patterns and mid-scan changes
    value = 16'h7FFF; hold_cycles(2 * SCAN + 3);
    value = 16'h8000; hold_cycles(SCAN + 7);
    value = 16'hFFFF; hold_cycles(SCAN + 1);
    value = 16'h1234; hold_cycles(3);
    value = 16'hA5C3; hold_cycles(SCAN - 2);
    value = 16'h5A3C; hold_cycles(2 * SCAN);
    // R1: reset in the middle of a scan
    rst = 1'b1; hold_cycles(2);
    rst = 1'b0; value = 16'hC0DE; hold_cycles(2 * SCAN + 9);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule